// File: doc/BRIEF.md
# Reversible AES-128 Round Key Sequencer

This block produces the AES-128 round keys one per clock without holding the expanded schedule anywhere. The only key storage is a 128-bit working register. Each step moves that register one round forward for encryption, or one round backward for decryption. A backward step recomputes the previous round's four words from the current four, so a decrypting datapath can begin at the last round key and walk down to the cipher key.

The user seeds the register with a 128-bit key and picks the direction at load time. After that, each step strobe advances the register once. Decryption needs the last round key as its seed. A derive command produces it: the block takes the cipher key, runs ten forward rounds by itself, shows a busy flag while it works, and then raises a ready flag. At that point the result is held in a separate output register, and the working register sits at round 10, ready for backward stepping.

Top module: `aes_ks_otf`

## Requirements
- R1: After reset, the working key, round index, busy flag, ready flag and latched final key are all zero.
- R2: A load (when not busy) places `seed_i` in `round_key_o` on the next clock. The index becomes 10 if `dir_bwd_i`=1 and 0 otherwise. The load clears `final_ready_o`.
- R3: A forward step (`step_i`=1, `dir_bwd_i`=0, index below 10) updates the key and increments the index. The key is four 32-bit words, word 0 in bits 127:96. The temporary t is SubWord(RotWord(word 3)) XOR {rcon,24'h0}. The new words are: n0 = w0^t, n1 = w1^n0, n2 = w2^n1, n3 = w3^n2.
- R4: A backward step (`dir_bwd_i`=1, index above 0) computes d = w2^w3, c = w1^w2, b = w0^w1, and a = w0 ^ SubWord(RotWord(d)) ^ {rcon,24'h0}. The new key is {a,b,c,d}, and the index decrements. Ten backward steps from the final round key return the cipher key.
- R5: rcon for round r (1..10) is 01,02,04,08,10,20,40,80,1B,36. A forward step that arrives at round r uses rcon[r]. A backward step that leaves round r uses rcon[r]. The key schedule of 2b7e151628aed2a6abf7158809cf4f3c ends at d014f9a8c9ee2589e13f0cc8b6630ca6.
- R6: A forward step at index 10 changes neither the key nor the index. A backward step at index 0 changes neither the key nor the index.
- R7: The derive command (`precompute_i`, when not busy) loads `seed_i` at index 0 and raises `busy_o`. It then advances one round per clock. On the clock that reaches index 10, `busy_o` drops, `final_ready_o` rises, and `final_key_o` takes the round-10 key.
- R8: While busy, load, step and derive inputs are ignored.
- R9: When several commands arrive together outside busy, load wins over derive, and derive wins over step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_i | input | 1 | Load seed into working register |
| seed_i | input | 128 | Seed key (cipher key or final round key) |
| dir_bwd_i | input | 1 | 1 = backward (decrypt) direction |
| step_i | input | 1 | Advance one round in the selected direction |
| precompute_i | input | 1 | Derive the final round key from seed_i |
| round_key_o | output | 128 | Current round key |
| round_idx_o | output | 4 | Current round index 0..10 |
| busy_o | output | 1 | Derivation in progress |
| final_ready_o | output | 1 | Derived final key valid |
| final_key_o | output | 128 | Latched final round key |

## Verification
The bench attacks both ends of the index range. A design that does not hold still at round 10 or at round 0 would run past the end, producing an eleventh key or wrapping the index. It checks the round constant at each boundary: an rcon that is off by one round gives a wrong key on the first forward step or on the last backward step, and the full-schedule vector exposes it. It injects loads and steps during derivation; a design that honours them would corrupt the latched final key or shorten the busy window. It also asserts commands at the same time, to expose a wrong priority.

// File: rtl/aes_ks_pkg.sv
package aes_ks_pkg;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 32;
    localparam int unsigned NWORDS  = 4;
    localparam int unsigned KEY_W   = WORD_W * NWORDS;
    localparam int unsigned ROUNDS  = 10;
    localparam int unsigned IDX_W   = $clog2(ROUNDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROUNDS);

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [WORD_W-1:0] word_t;
    typedef logic [KEY_W-1:0]  key_t;
    typedef logic [IDX_W-1:0]  idx_t;

    typedef struct packed {
        key_t  key;
        idx_t  idx;
        logic  busy;
        logic  ready;
        key_t  fin;
    } ks_state_t;

    function automatic byte_t xtime(byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(byte_t a, byte_t b);
        byte_t p;
        byte_t t;
        p = '0;
        t = a;
        for (int i = 0; i < BYTE_W; i++) begin
            if (b[i]) p = p ^ t;
            t = xtime(t);
        end
        return p;
    endfunction

    // Round constant for round r (1..ROUNDS): doubling in GF(2^8)
    function automatic byte_t rcon_of(idx_t r);
        byte_t c;
        c = 8'h01;
        for (int i = 2; i <= int'(ROUNDS); i++) begin
            if (i <= int'(r)) c = xtime(c);
        end
        return c;
    endfunction
endpackage

// File: rtl/aes_sbox.sv
module aes_sbox
    import aes_ks_pkg::*;
(
    input  byte_t in_i,
    output byte_t out_i
);
    localparam byte_t INV_EXP = 8'd254;

    byte_t inv_v;
    byte_t pow_v;

    // Multiplicative inverse as x^254 (zero maps to zero), then affine map
    always_comb begin
        inv_v = 8'h01;
        pow_v = in_i;
        for (int i = 0; i < BYTE_W; i++) begin
            if (INV_EXP[i]) inv_v = gf_mul(inv_v, pow_v);
            pow_v = gf_mul(pow_v, pow_v);
        end
        out_i = inv_v
              ^ {inv_v[6:0], inv_v[7]}
              ^ {inv_v[5:0], inv_v[7:6]}
              ^ {inv_v[4:0], inv_v[7:5]}
              ^ {inv_v[3:0], inv_v[7:4]}
              ^ 8'h63;
    end
endmodule

// File: rtl/aes_subword.sv
module aes_subword
    import aes_ks_pkg::*;
(
    input  word_t word_i,
    output word_t word_o
);
    localparam int unsigned NB = WORD_W / BYTE_W;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        aes_sbox u_sbox (
            .in_i  (word_i[g*BYTE_W +: BYTE_W]),
            .out_i (word_o[g*BYTE_W +: BYTE_W])
        );
    end
endmodule

// File: rtl/aes_ks_round.sv
module aes_ks_round
    import aes_ks_pkg::*;
(
    input  key_t  cur_i,
    input  logic  bwd_i,
    input  byte_t rcon_i,
    output key_t  nxt_o
);
    word_t w0, w1, w2, w3;
    word_t sub_in, rot, sw, f;
    word_t n0, n1, n2, n3;
    word_t a0, b0, c0, d0;

    assign w0 = cur_i[KEY_W-1          -: WORD_W];
    assign w1 = cur_i[KEY_W-1-WORD_W   -: WORD_W];
    assign w2 = cur_i[KEY_W-1-2*WORD_W -: WORD_W];
    assign w3 = cur_i[WORD_W-1:0];

    // One shared SubWord: forward feeds word 3, backward feeds recovered d
    assign sub_in = bwd_i ? (w2 ^ w3) : w3;
    assign rot    = {sub_in[WORD_W-BYTE_W-1:0], sub_in[WORD_W-1 -: BYTE_W]};

    aes_subword u_sub (
        .word_i (rot),
        .word_o (sw)
    );

    assign f = sw ^ {rcon_i, {(WORD_W-BYTE_W){1'b0}}};

    assign n0 = w0 ^ f;
    assign n1 = w1 ^ n0;
    assign n2 = w2 ^ n1;
    assign n3 = w3 ^ n2;

    assign d0 = w2 ^ w3;
    assign c0 = w1 ^ w2;
    assign b0 = w0 ^ w1;
    assign a0 = w0 ^ f;

    assign nxt_o = bwd_i ? {a0, b0, c0, d0} : {n0, n1, n2, n3};
endmodule

// File: rtl/aes_ks_otf.sv
module aes_ks_otf
    import aes_ks_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [127:0] seed_i,
    input  logic         dir_bwd_i,
    input  logic         step_i,
    input  logic         precompute_i,
    output logic [127:0] round_key_o,
    output logic [3:0]   round_idx_o,
    output logic         busy_o,
    output logic         final_ready_o,
    output logic [127:0] final_key_o
);
    ks_state_t s_d, s_q;

    logic  use_bwd;
    idx_t  rc_idx;
    byte_t rcon;
    key_t  nxt_key;

    // Derivation always runs forward; otherwise the direction input decides
    assign use_bwd = dir_bwd_i && !s_q.busy;
    assign rc_idx  = use_bwd ? s_q.idx : s_q.idx + idx_t'(1);
    assign rcon    = rcon_of(rc_idx);

    aes_ks_round u_round (
        .cur_i  (s_q.key),
        .bwd_i  (use_bwd),
        .rcon_i (rcon),
        .nxt_o  (nxt_key)
    );

    always_comb begin
        s_d = s_q;
        if (s_q.busy) begin
            s_d.key = nxt_key;
            s_d.idx = s_q.idx + idx_t'(1);
            if (s_q.idx == LAST_IDX - idx_t'(1)) begin
                s_d.busy  = 1'b0;
                s_d.ready = 1'b1;
                s_d.fin   = nxt_key;
            end
        end else if (load_i) begin
            s_d.key   = seed_i;
            s_d.idx   = dir_bwd_i ? LAST_IDX : '0;
            s_d.ready = 1'b0;
        end else if (precompute_i) begin
            s_d.key   = seed_i;
            s_d.idx   = '0;
            s_d.busy  = 1'b1;
            s_d.ready = 1'b0;
        end else if (step_i) begin
            if (dir_bwd_i && s_q.idx != '0) begin
                s_d.key = nxt_key;
                s_d.idx = s_q.idx - idx_t'(1);
            end else if (!dir_bwd_i && s_q.idx < LAST_IDX) begin
                s_d.key = nxt_key;
                s_d.idx = s_q.idx + idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign round_key_o   = s_q.key;
    assign round_idx_o   = s_q.idx;
    assign busy_o        = s_q.busy;
    assign final_ready_o = s_q.ready;
    assign final_key_o   = s_q.fin;

    // R3 / R4: index never leaves 0..10
    p_idx_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        round_idx_o <= LAST_IDX);

    p_load_idx_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !busy_o) |=>
            (round_key_o == $past(seed_i)) &&
            (round_idx_o == ($past(dir_bwd_i) ? LAST_IDX : idx_t'(0))) && !final_ready_o);

    p_fwd_idx_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !dir_bwd_i && !load_i && !precompute_i && !busy_o && round_idx_o < LAST_IDX)
            |=> round_idx_o == $past(round_idx_o) + idx_t'(1));

    p_bwd_idx_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_bwd_i && !load_i && !precompute_i && !busy_o && round_idx_o != '0)
            |=> round_idx_o == $past(round_idx_o) - idx_t'(1));

    p_top_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !dir_bwd_i && !load_i && !precompute_i && !busy_o && round_idx_o == LAST_IDX)
            |=> $stable(round_key_o) && $stable(round_idx_o));

    p_bottom_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && dir_bwd_i && !load_i && !precompute_i && !busy_o && round_idx_o == '0)
            |=> $stable(round_key_o) && $stable(round_idx_o));

    p_done_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> final_ready_o && final_key_o == round_key_o && round_idx_o == LAST_IDX);

    p_busy_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> round_idx_o == $past(round_idx_o) + idx_t'(1));

    p_ready_not_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(final_ready_o && busy_o));
endmodule

// File: tb/aes_ks_otf_bench.sv
module aes_ks_otf_bench;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         load_i = 1'b0;
    logic [127:0] seed_i = '0;
    logic         dir_bwd_i = 1'b0;
    logic         step_i = 1'b0;
    logic         precompute_i = 1'b0;
    logic [127:0] round_key_o;
    logic [3:0]   round_idx_o;
    logic         busy_o;
    logic         final_ready_o;
    logic [127:0] final_key_o;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    localparam logic [127:0] SCHED [11] = '{
        128'h2b7e151628aed2a6abf7158809cf4f3c,
        128'ha0fafe1788542cb123a339392a6c7605,
        128'hf2c295f27a96b9435935807a7359f67f,
        128'h3d80477d4716fe3e1e237e446d7a883b,
        128'hef44a541a8525b7fb671253bdb0bad00,
        128'hd4d1c6f87c839d87caf2b8bc11f915bc,
        128'h6d88a37a110b3efddbf98641ca0093fd,
        128'h4e54f70e5f5fc9f384a64fb24ea6dc4f,
        128'head27321b58dbad2312bf5607f8d292f,
        128'hac7766f319fadc2128d12941575c006e,
        128'hd014f9a8c9ee2589e13f0cc8b6630ca6
    };
    localparam logic [127:0] ALT_KEY = 128'h00112233445566778899aabbccddeeff;

    aes_ks_otf u_aes_ks_otf (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_i        (load_i),
        .seed_i        (seed_i),
        .dir_bwd_i     (dir_bwd_i),
        .step_i        (step_i),
        .precompute_i  (precompute_i),
        .round_key_o   (round_key_o),
        .round_idx_o   (round_idx_o),
        .busy_o        (busy_o),
        .final_ready_o (final_ready_o),
        .final_key_o   (final_key_o)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive at a falling edge, let one rising edge capture, return at the next falling edge
    task automatic cmd(logic ld, logic pc, logic st, logic dir, logic [127:0] sd);
        load_i = ld; precompute_i = pc; step_i = st; dir_bwd_i = dir; seed_i = sd;
        @(negedge clk);
        load_i = 1'b0; precompute_i = 1'b0; step_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 key", round_key_o, '0);
        chk("R1 idx", 128'(round_idx_o), '0);
        chk("R1 flags", 128'({busy_o, final_ready_o}), '0);
        chk("R1 final", final_key_o, '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2 forward load, R3/R5 walk the whole schedule forward
        cmd(1, 0, 0, 0, SCHED[0]);
        chk("R2 load fwd key", round_key_o, SCHED[0]);
        chk("R2 load fwd idx", 128'(round_idx_o), 128'(0));
        for (int r = 1; r <= 10; r++) begin
            cmd(0, 0, 1, 0, '0);
            chk("R3 R5 fwd key", round_key_o, SCHED[r]);
            chk("R3 fwd idx", 128'(round_idx_o), 128'(r));
        end
        // R6 forward step at top is ignored
        cmd(0, 0, 1, 0, '0);
        chk("R6 top key", round_key_o, SCHED[10]);
        chk("R6 top idx", 128'(round_idx_o), 128'(10));

        // R2 backward load, R4 walk back to cipher key
        cmd(1, 0, 0, 1, SCHED[10]);
        chk("R2 load bwd idx", 128'(round_idx_o), 128'(10));
        for (int r = 9; r >= 0; r--) begin
            cmd(0, 0, 1, 1, '0);
            chk("R4 bwd key", round_key_o, SCHED[r]);
            chk("R4 bwd idx", 128'(round_idx_o), 128'(r));
        end
        // R6 backward step at bottom is ignored
        cmd(0, 0, 1, 1, '0);
        chk("R6 bottom key", round_key_o, SCHED[0]);
        chk("R6 bottom idx", 128'(round_idx_o), 128'(0));

        // R7 derive, R8 inputs ignored while busy
        cmd(0, 1, 0, 0, SCHED[0]);
        chk("R7 busy start", 128'({busy_o, final_ready_o}), 128'(2));
        chk("R7 idx start", 128'(round_idx_o), 128'(0));
        cmd(1, 1, 1, 1, ALT_KEY);          // edge 1: must be ignored (R8)
        chk("R8 idx during busy", 128'(round_idx_o), 128'(1));
        chk("R8 key during busy", round_key_o, SCHED[1]);
        for (int k = 2; k <= 9; k++) @(negedge clk);
        chk("R7 still busy at 9", 128'({busy_o, final_ready_o}), 128'(2));
        @(negedge clk);
        chk("R7 ready flags", 128'({busy_o, final_ready_o}), 128'(1));
        chk("R7 final key", final_key_o, SCHED[10]);
        chk("R7 round key", round_key_o, SCHED[10]);
        chk("R7 idx 10", 128'(round_idx_o), 128'(10));

        // Backward right after derivation
        cmd(0, 0, 1, 1, '0);
        chk("R4 after derive", round_key_o, SCHED[9]);

        // R9 priority: load beats derive and step; load clears ready (R2)
        cmd(1, 1, 1, 0, ALT_KEY);
        chk("R9 load wins key", round_key_o, ALT_KEY);
        chk("R9 load wins flags", 128'({busy_o, final_ready_o}), 128'(0));
        chk("R9 final kept", final_key_o, SCHED[10]);
        // R9 derive beats step
        cmd(0, 1, 1, 1, SCHED[0]);
        chk("R9 derive wins", 128'({busy_o, round_idx_o}), 128'({1'b1, 4'd0}));
        for (int k = 1; k <= 10; k++) @(negedge clk);
        chk("R9 derive result", final_key_o, SCHED[10]);

        // R1 reset mid-run
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 reset again", round_key_o | final_key_o, '0);
        rst_n = 1'b1;

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule